// File: doc/BRIEF.md
# Voltage-Mode PWM Latch Controller with Cycle Current Limit

This block is the digital core of a voltage-mode pulse-width modulator for a synchronous buck stage. A phase counter plays the part of the PWM ramp. The first `PULSE_CYC` counts of each period form the oscillator pulse. The remaining counts form a rising ramp that is compared against an error-amplifier code. The pulse sets a PWM latch. The latch is cleared when the ramp reaches the error code, or when a qualified current-limit trip occurs. While the latch is set, the block requests high-side conduction.

The requested state drives two registered gate commands, one for the high-side switch and one for the low-side switch. A gate command turns on only when a feedback input reports that the opposite gate has fallen below its low threshold. This gives adaptive dead time without a fixed delay.

The period has three sources: a slow fixed choice, a fast fixed choice, or a programmed value limited to a legal window. The over-current input is ignored for a blanking interval at the start of each high-side on-time. It must then persist for several cycles before it cuts that cycle's pulse short.

Top module: `pwm_latch_ctrl`

## Requirements
- R1: While `rst_n` is low, both `hs_on` and `ls_on` are low. The phase restarts at 0 when reset is released.
- R2: `freq_sel` = 2'b00 selects a period of `PER_SLOW` clocks (default 80). `freq_sel` = 2'b01 selects `PER_FAST` clocks (default 50). The period is measured between successive rising edges of `hs_on`.
- R3: When `freq_sel[1]` = 1, the period is `prog_period`, clamped to the range [`PER_MIN`, `PER_MAX`] (defaults 20 and 200).
- R4: The first `PULSE_CYC` phases of each period are the oscillator pulse. `hs_on` is low in every cycle that follows a pulse phase. This guarantees a minimum off-time of at least `PULSE_CYC` cycles per period.
- R5: Let L = period − `PULSE_CYC` and E = `err_code`. Assume ideal gate feedback, in which a gate reads low in the cycle after its command drops. Then `hs_on` is high for max(min(E, L) − 1, 0) cycles per period.
- R6: `err_code` = 0 keeps the latch reset, so no high-side pulse occurs in the period.
- R7: `err_code` ≥ L never resets the latch through the comparator. The high side then stays on until the next pulse, for L − 1 cycles.
- R8: `ilim_trip` is ignored during the first `BLANK_CYC` cycles of each high-side on-time.
- R9: A trip must persist. After `PERSIST_CYC` consecutive qualified trip cycles, the latch resets and `hs_on` falls one cycle later. With the trip held high, the on-time is `BLANK_CYC` + `PERSIST_CYC` + 1 cycles, and the check repeats every period.
- R10: `ilim_trip` has no effect while `hs_on` is low.
- R11: `hs_on` rises only if `ls_gate_low` was high and `ls_on` was low in the previous cycle. `ls_on` rises only if `hs_gate_low` was high and `hs_on` was low in the previous cycle. If a gate never reads low, the opposite switch never turns on.
- R12: `hs_on` and `ls_on` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_sel | input | 2 | 00 slow fixed period, 01 fast fixed period, 1x programmed period |
| prog_period | input | CNT_W | Programmed period in clocks |
| err_code | input | CNT_W | Error-amplifier code compared with the ramp |
| ilim_trip | input | 1 | Over-current comparator output |
| hs_gate_low | input | 1 | High-side gate reads below its low threshold |
| ls_gate_low | input | 1 | Low-side gate reads below its low threshold |
| hs_on | output | 1 | High-side gate command |
| ls_on | output | 1 | Low-side gate command |

## Verification
Every gate command is registered, so a change in the inputs shows at `hs_on`/`ls_on` on the next rising edge. A hand-off between the switches costs two such edges: the releasing gate falls, then its feedback reads low, then the other gate rises. A qualified over-current trip removes the high side `PERSIST_CYC` + 1 edges after the first qualified cycle. The bench keeps these latencies exact by advancing a behavioural model by one step for each clock. The model is stepped with the input values the design will sample at that clock. Both outputs are compared at the following falling edge. Per-period figures (on-time counts and intervals between rising edges) are taken over a window of exactly one period. The window is opened only after a settling run of several periods.

// File: rtl/pwm_latch_ctrl.sv
module pwm_latch_ctrl #(
  parameter int CNT_W       = 8,
  parameter int PULSE_CYC   = 3,
  parameter int BLANK_CYC   = 2,
  parameter int PERSIST_CYC = 2,
  parameter int PER_SLOW    = 80,
  parameter int PER_FAST    = 50,
  parameter int PER_MIN     = 20,
  parameter int PER_MAX     = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       freq_sel,
  input  logic [CNT_W-1:0] prog_period,
  input  logic [CNT_W-1:0] err_code,
  input  logic             ilim_trip,
  input  logic             hs_gate_low,
  input  logic             ls_gate_low,
  output logic             hs_on,
  output logic             ls_on
);
  localparam int BW = $clog2(BLANK_CYC + 1) + 1;
  localparam int TW = $clog2(PERSIST_CYC + 1) + 1;
  localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);
  localparam logic [CNT_W-1:0] PULSE_V = CNT_W'(PULSE_CYC);
  localparam logic [CNT_W-1:0] SLOW_V  = CNT_W'(PER_SLOW);
  localparam logic [CNT_W-1:0] FAST_V  = CNT_W'(PER_FAST);
  localparam logic [CNT_W-1:0] MIN_V   = CNT_W'(PER_MIN);
  localparam logic [CNT_W-1:0] MAX_V   = CNT_W'(PER_MAX);
  localparam logic [BW-1:0]    BLANK_V = BW'(BLANK_CYC);
  localparam logic [TW-1:0]    PERS_V  = TW'(PERSIST_CYC);

  logic [CNT_W-1:0] ph, per, prog_lim, ramp;
  logic [BW-1:0]    on_cnt;
  logic [TW-1:0]    trip_cnt;
  logic             latch, osc_pulse, cmp_trip, ilim_cut, hs_want, qual_trip;

  assign prog_lim  = (prog_period < MIN_V) ? MIN_V :
                     (prog_period > MAX_V) ? MAX_V : prog_period;
  assign per       = freq_sel[1] ? prog_lim : (freq_sel[0] ? FAST_V : SLOW_V);
  assign osc_pulse = ph < PULSE_V;
  assign ramp      = ph - PULSE_V;
  assign cmp_trip  = !osc_pulse && (ramp >= err_code);
  assign ilim_cut  = trip_cnt >= PERS_V;
  assign hs_want   = latch && !osc_pulse && !cmp_trip && !ilim_cut;
  assign qual_trip = hs_on && (on_cnt >= BLANK_V) && ilim_trip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= '0;
      latch    <= 1'b0;
      hs_on    <= 1'b0;
      ls_on    <= 1'b0;
      on_cnt   <= '0;
      trip_cnt <= '0;
    end else begin
      ph <= (ph >= per - ONE_V) ? '0 : ph + ONE_V;
      if (osc_pulse)
        latch <= 1'b1;
      else if (cmp_trip || ilim_cut)
        latch <= 1'b0;
      hs_on <= hs_want && ls_gate_low && !ls_on;
      ls_on <= !hs_want && hs_gate_low && !hs_on;
      if (!hs_on)
        on_cnt <= '0;
      else if (on_cnt < BLANK_V)
        on_cnt <= on_cnt + BW'(1);
      if (!qual_trip)
        trip_cnt <= '0;
      else if (!ilim_cut)
        trip_cnt <= trip_cnt + TW'(1);
    end
  end
endmodule

// File: rtl/pwm_latch_ctrl_chk.sv
module pwm_latch_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic hs_on,
  input logic ls_on,
  input logic hs_gate_low,
  input logic ls_gate_low,
  input logic osc_pulse,
  input logic ilim_cut
);
  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  assert_hs_waits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> ($past(ls_gate_low) && !$past(ls_on)));

  assert_ls_waits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> ($past(hs_gate_low) && !$past(hs_on)));

  assert_pulse_blocks_hs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    osc_pulse |=> !hs_on);

  assert_ilim_cuts_hs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_cut |=> !hs_on);
endmodule

bind pwm_latch_ctrl pwm_latch_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_on(hs_on), .ls_on(ls_on),
  .hs_gate_low(hs_gate_low), .ls_gate_low(ls_gate_low),
  .osc_pulse(osc_pulse), .ilim_cut(ilim_cut)
);

// File: tb/pwm_latch_ctrl_test.sv
module pwm_latch_ctrl_test;
  localparam int CLK_P  = 10;
  localparam int WD_CYC = 150000;
  localparam int PULSE  = 3, BLANK = 2, PERSIST = 2;
  localparam int PSLOW = 80, PFAST = 50, PMIN = 20, PMAX = 200;

  logic clk = 0, rst_n = 0;
  logic [1:0] freq_sel = 0;
  logic [7:0] prog_period = 0, err_code = 0;
  logic ilim_trip = 0, hs_gate_low = 1, ls_gate_low = 1;
  logic hs_on, ls_on;

  pwm_latch_ctrl uut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  int m_ph = 0, m_on = 0, m_trip = 0;
  bit m_latch = 0, m_hs = 0, m_ls = 0;
  int cyc = 0, last_rise = -1, interval = 0, run_k = 0, n_hs = 0, n_ls = 0;
  bit prev_hs = 0, stuck_hs = 0, stuck_ls = 0;
  int ilim_mode = 0;
  string cur_req = "R1";

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int period_of();
    int p;
    if (freq_sel[1]) begin
      p = prog_period;
      if (p < PMIN) p = PMIN;
      if (p > PMAX) p = PMAX;
    end else p = freq_sel[0] ? PFAST : PSLOW;
    return p;
  endfunction

  task automatic tick();
    int per, ramp, n_on, n_tr, n_ph;
    bit pulse, cut, cmp, want, nh, nl, nlat;
    if (!rst_n) begin
      n_ph = 0; nlat = 0; nh = 0; nl = 0; n_on = 0; n_tr = 0;
    end else begin
      per   = period_of();
      pulse = m_ph < PULSE;
      ramp  = m_ph - PULSE;
      cut   = m_trip >= PERSIST;
      cmp   = !pulse && ramp >= int'(err_code);
      want  = m_latch && !pulse && !cmp && !cut;
      nh    = want && ls_gate_low && !m_ls;
      nl    = !want && hs_gate_low && !m_hs;
      n_on  = m_hs ? ((m_on < BLANK) ? m_on + 1 : m_on) : 0;
      n_tr  = (m_hs && m_on >= BLANK && ilim_trip) ? ((m_trip < PERSIST) ? m_trip + 1 : m_trip) : 0;
      nlat  = pulse ? 1'b1 : ((cmp || cut) ? 1'b0 : m_latch);
      n_ph  = (m_ph >= per - 1) ? 0 : m_ph + 1;
    end
    @(negedge clk);
    m_ph = n_ph; m_latch = nlat; m_hs = nh; m_ls = nl; m_on = n_on; m_trip = n_tr;
    cyc++;
    chk({hs_on, ls_on} == {m_hs, m_ls}, cur_req, {hs_on, ls_on}, {m_hs, m_ls});
    chk(!(hs_on && ls_on), "R12", {hs_on, ls_on}, 0);
    if (hs_on) n_hs++;
    if (ls_on) n_ls++;
    if (hs_on && !prev_hs) begin
      if (last_rise >= 0) interval = cyc - last_rise;
      last_rise = cyc;
    end
    prev_hs = hs_on;
    run_k = hs_on ? run_k + 1 : 0;
    hs_gate_low = stuck_hs ? 1'b0 : !hs_on;
    ls_gate_low = stuck_ls ? 1'b0 : !ls_on;
    case (ilim_mode)
      1: ilim_trip = hs_on && run_k <= BLANK;
      2: ilim_trip = hs_on && run_k == BLANK + 1;
      3: ilim_trip = 1'b1;
      4: ilim_trip = !hs_on;
      default: ilim_trip = 1'b0;
    endcase
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic measure(int p);
    run(3 * p);
    n_hs = 0; n_ls = 0;
    run(p);
  endtask

  initial begin
    #(CLK_P * WD_CYC);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    run(4);
    chk(!hs_on && !ls_on, "R1", {hs_on, ls_on}, 0);
    rst_n = 1;

    cur_req = "R2"; err_code = 10; freq_sel = 2'b00;
    measure(PSLOW);
    chk(interval == PSLOW, "R2", interval, PSLOW);
    chk(n_hs == 9, "R5", n_hs, 9);
    freq_sel = 2'b01;
    measure(PFAST);
    chk(interval == PFAST, "R2", interval, PFAST);

    cur_req = "R3"; freq_sel = 2'b10; prog_period = 30;
    measure(30);
    chk(interval == 30, "R3", interval, 30);
    prog_period = 5;
    measure(PMIN);
    chk(interval == PMIN, "R3", interval, PMIN);
    prog_period = 250;
    measure(PMAX);
    chk(interval == PMAX, "R3", interval, PMAX);

    cur_req = "R6"; freq_sel = 2'b00; err_code = 0;
    measure(PSLOW);
    chk(n_hs == 0, "R6", n_hs, 0);
    cur_req = "R5"; err_code = 1;
    measure(PSLOW);
    chk(n_hs == 0, "R5", n_hs, 0);
    err_code = 76;
    measure(PSLOW);
    chk(n_hs == 75, "R5", n_hs, 75);
    cur_req = "R7"; err_code = 77;
    measure(PSLOW);
    chk(n_hs == 76, "R7", n_hs, 76);
    err_code = 200;
    measure(PSLOW);
    chk(n_hs == 76, "R7", n_hs, 76);
    chk(PSLOW - n_hs >= PULSE, "R4", PSLOW - n_hs, PULSE);

    err_code = 40;
    cur_req = "R8"; ilim_mode = 1;
    measure(PSLOW);
    chk(n_hs == 39, "R8", n_hs, 39);
    cur_req = "R9"; ilim_mode = 2;
    measure(PSLOW);
    chk(n_hs == 39, "R9", n_hs, 39);
    ilim_mode = 3;
    measure(PSLOW);
    chk(n_hs == BLANK + PERSIST + 1, "R9", n_hs, BLANK + PERSIST + 1);
    cur_req = "R10"; ilim_mode = 4;
    measure(PSLOW);
    chk(n_hs == 39, "R10", n_hs, 39);
    ilim_mode = 0;

    cur_req = "R11"; stuck_ls = 1;
    measure(PSLOW);
    chk(n_hs == 0, "R11", n_hs, 0);
    stuck_ls = 0; stuck_hs = 1;
    measure(PSLOW);
    chk(n_ls == 0, "R11", n_ls, 0);
    stuck_hs = 0;
    measure(PSLOW);
    chk(n_hs == 39, "R11", n_hs, 39);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule